// File: doc/BRIEF.md
# Receive FIFO Flow-Control Alert Generator

This block sits beside the receive FIFO of an Ethernet MAC and decides when the MAC should ask its link partner to pause. It keeps two occupancy counts. One counts the data bytes held in the FIFO. The other counts the complete frames held in the FIFO. The counts follow the write-side and read-side strobes of the FIFO. Each count is compared with a threshold taken from one 32-bit control register. That register is written and read over a plain strobe-and-data bus.

The pause alert rises as soon as either count reaches its threshold. It falls only once both counts are below their thresholds. The byte threshold is set in 256-byte steps, and the FIFO capacity is set the same way by a depth selector input. A byte threshold at or above the capacity is clamped to it. In that case the alert fires 64 bytes before the FIFO is full, which leaves room for data that is still arriving.

Top module: `rxfa_top`

## Requirements
- R1: After reset the register reads 0x001F00FF: frame field (bits 20:16) = 0x1F, byte field (bits 7:0) = 0xFF. The alert output is 0.
- R2: A register write loads bits 20:16 and 7:0 from the write data. Bits 31:21 and 15:8 always read as 0, whatever value is written.
- R3: A frame field value N of 0x17 or less raises the alert once at least N+1 frames are stored.
- R4: A frame field value above 0x17 acts as 24 frames.
- R5: A byte field value T below the depth selector D raises the alert once at least (T+1)*256 bytes are stored.
- R6: A byte field value equal to D raises the alert once at least (D+1)*256-64 bytes are stored.
- R7: A byte field value above D acts exactly as a value equal to D.
- R8: The alert is the OR of the frame condition and the byte condition. It stays high while either condition holds and falls only when neither holds.
- R9: The frame count rises by 1 on a write-side end-of-frame strobe and falls by 1 on a read-side end-of-frame strobe. Both strobes in the same cycle leave the count unchanged. A read strobe at zero leaves the count at zero.
- R10: Each cycle the byte count adds the bytes written and subtracts the bytes read. The result is held between 0 and (D+1)*256.
- R11: The alert is registered. It reflects the counts and register contents one clock after they update, so it changes two clock edges after the strobe or write that caused the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| depth_sel | input | 8 | FIFO capacity in 256-byte steps, value D means (D+1)*256 bytes |
| wr_bytes | input | 5 | Bytes written into the FIFO this cycle |
| rd_bytes | input | 5 | Bytes read out of the FIFO this cycle |
| wr_eof | input | 1 | A frame finished being written this cycle |
| rd_eof | input | 1 | A frame finished being read this cycle |
| alert | output | 1 | Flow-control (pause request) alert |

## Verification
The counters and thresholds are hidden, so any error in them shows up only in the alert timing. A byte count that drifts by a single 16-byte beat moves the alert edge by one cycle, and the bench sees this because it compares the alert in every cycle. A frame count that wraps below zero, or a byte count that does not saturate at the FIFO capacity, shows up tens of cycles later: the next threshold crossing comes at the wrong cycle. The release checks catch an alert that stays latched.

// File: rtl/rxfa_pkg.sv
// Package: shared field layout and limits for the receive FIFO alert block.
// Assumes the register layout is fixed; widths of counters are module params.
package rxfa_pkg;
    localparam int FRM_FIELD_W = 5;
    localparam int DAT_FIELD_W = 8;
    localparam int FRM_LSB     = 16;
    localparam int DAT_LSB     = 0;
    localparam int FRM_CAP     = 23;   // largest field value with its own meaning
    localparam logic [FRM_FIELD_W-1:0] FRM_RST = 5'h1F;
    localparam logic [DAT_FIELD_W-1:0] DAT_RST = 8'hFF;

    typedef struct packed {
        logic [FRM_FIELD_W-1:0] frm_thr;
        logic [DAT_FIELD_W-1:0] dat_thr;
    } thr_cfg_t;
endpackage

// File: rtl/rxfa_cfg_reg.sv
// Module: threshold control register.
// Holds the frame-count and byte-count threshold fields. Other bits read 0.
// Assumes a single register, so no address decode is needed.
module rxfa_cfg_reg
    import rxfa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output thr_cfg_t    cfg
);
    // Reserved write bits are dropped on purpose.
    logic unused_rsvd;
    assign unused_rsvd = ^{reg_wdata[31:21], reg_wdata[15:8]};

    // Purpose: load both threshold fields on a write, restore defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.frm_thr <= FRM_RST;
            cfg.dat_thr <= DAT_RST;
        end else if (reg_wr) begin
            cfg.frm_thr <= reg_wdata[FRM_LSB +: FRM_FIELD_W];
            cfg.dat_thr <= reg_wdata[DAT_LSB +: DAT_FIELD_W];
        end
    end

    // Purpose: place the fields at their bit positions, zeros elsewhere.
    always_comb begin
        reg_rdata = '0;
        reg_rdata[FRM_LSB +: FRM_FIELD_W] = cfg.frm_thr;
        reg_rdata[DAT_LSB +: DAT_FIELD_W] = cfg.dat_thr;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[20:16] == $past(reg_wdata[20:16]))
                && (reg_rdata[7:0] == $past(reg_wdata[7:0]))); // R2
    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(cfg)); // R2
endmodule

// File: rtl/rxfa_occupancy.sv
// Module: byte and frame occupancy counters of the receive FIFO.
// The byte count is held between zero and the configured capacity.
// The frame count saturates at zero and at its all-ones value.
// Assumes the strobes describe the FIFO faithfully; no error is flagged.
module rxfa_occupancy #(
    parameter int DSEL_W  = 8,
    parameter int BEAT_W  = 5,
    parameter int GRAN_SH = 8,
    parameter int FCNT_W  = 6,
    localparam int BCNT_W = DSEL_W + GRAN_SH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DSEL_W-1:0] depth_sel,
    input  logic [BEAT_W-1:0] wr_bytes,
    input  logic [BEAT_W-1:0] rd_bytes,
    input  logic              wr_eof,
    input  logic              rd_eof,
    output logic [BCNT_W-1:0] byte_cnt,
    output logic [FCNT_W-1:0] frm_cnt
);
    localparam logic [FCNT_W-1:0] FCNT_MAX = '1;

    logic [BCNT_W-1:0] depth_bytes;
    logic [BCNT_W:0]   sum_in;
    logic [BCNT_W:0]   diff;
    logic [BCNT_W-1:0] byte_nxt;
    logic [FCNT_W-1:0] frm_nxt;

    // Purpose: capacity in bytes from the 256-byte-step selector.
    always_comb begin
        depth_bytes = (BCNT_W'(depth_sel) + BCNT_W'(1)) << GRAN_SH;
    end

    // Purpose: add written bytes, remove read bytes, clamp to [0, capacity].
    always_comb begin
        sum_in = {1'b0, byte_cnt} + (BCNT_W + 1)'(wr_bytes);
        diff   = '0;
        if (sum_in < (BCNT_W + 1)'(rd_bytes)) begin
            byte_nxt = '0;
        end else begin
            diff = sum_in - (BCNT_W + 1)'(rd_bytes);
            if (diff > {1'b0, depth_bytes}) byte_nxt = depth_bytes;
            else                            byte_nxt = diff[BCNT_W-1:0];
        end
    end

    // Purpose: step the frame count on one-sided end-of-frame strobes.
    always_comb begin
        frm_nxt = frm_cnt;
        if (wr_eof && !rd_eof && frm_cnt != FCNT_MAX) frm_nxt = frm_cnt + 1'b1;
        if (rd_eof && !wr_eof && frm_cnt != '0)       frm_nxt = frm_cnt - 1'b1;
    end

    // Purpose: hold both counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            frm_cnt  <= '0;
        end else begin
            byte_cnt <= byte_nxt;
            frm_cnt  <= frm_nxt;
        end
    end

    AST_FRM_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_eof && rd_eof) |=> $stable(frm_cnt)); // R9
    AST_FRM_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_eof && !rd_eof && frm_cnt != FCNT_MAX) |=> frm_cnt == $past(frm_cnt) + 1'b1); // R9
    AST_FRM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_eof && !wr_eof && frm_cnt == '0) |=> frm_cnt == '0); // R9
    AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> byte_cnt <= $past(depth_bytes)); // R10
endmodule

// File: rtl/rxfa_compare.sv
// Module: threshold comparison and registered alert.
// Derives the effective frame and byte limits from the register fields and
// the depth selector, then ORs the two conditions into a registered alert.
// Assumes counts and fields are already registered upstream.
module rxfa_compare
    import rxfa_pkg::*;
#(
    parameter int DSEL_W      = 8,
    parameter int GRAN_SH     = 8,
    parameter int FCNT_W      = 6,
    parameter int GUARD_BYTES = 64,
    localparam int BCNT_W     = DSEL_W + GRAN_SH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  thr_cfg_t          cfg,
    input  logic [DSEL_W-1:0] depth_sel,
    input  logic [BCNT_W-1:0] byte_cnt,
    input  logic [FCNT_W-1:0] frm_cnt,
    output logic              alert
);
    logic              at_depth;
    logic [DSEL_W-1:0] eff_sel;
    logic [BCNT_W-1:0] lim_full;
    logic [BCNT_W-1:0] byte_lim;
    logic [FCNT_W-1:0] frm_need;
    logic              hit_frm;
    logic              hit_byte;

    // Purpose: clamp the byte field to the configured capacity.
    always_comb begin
        at_depth = (DSEL_W'(cfg.dat_thr) >= depth_sel);
        eff_sel  = at_depth ? depth_sel : DSEL_W'(cfg.dat_thr);
        lim_full = (BCNT_W'(eff_sel) + BCNT_W'(1)) << GRAN_SH;
    end

    // Pick the byte limit; the guard band applies only at full capacity.
    generate
        if (GUARD_BYTES == 0) begin : g_no_guard
            assign byte_lim = lim_full;
        end else begin : g_guard
            assign byte_lim = at_depth ? (lim_full - BCNT_W'(GUARD_BYTES)) : lim_full;
        end
    endgenerate

    // Purpose: frame field is N+1 frames, capped past the last coded value.
    always_comb begin
        if (int'(cfg.frm_thr) > FRM_CAP) frm_need = FCNT_W'(FRM_CAP + 1);
        else                             frm_need = FCNT_W'(cfg.frm_thr) + FCNT_W'(1);
    end

    // Purpose: the two raw conditions.
    always_comb begin
        hit_frm  = (frm_cnt >= frm_need);
        hit_byte = (byte_cnt >= byte_lim);
    end

    // Purpose: register the OR of both conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) alert <= 1'b0;
        else        alert <= hit_frm | hit_byte;
    end

    AST_ALERT_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_cnt == '0 && byte_cnt == '0) |=> !alert); // R8
    AST_ALERT_FRM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(frm_cnt) >= FRM_CAP + 1) |=> alert); // R4
endmodule

// File: rtl/rxfa_top.sv
// Module: receive FIFO flow-control alert generator, top level.
// Connects the control register, occupancy counters and comparator.
// Assumes byte strobes never exceed BEAT_BYTES per cycle.
module rxfa_top #(
    parameter int BEAT_BYTES  = 16,
    parameter int FCNT_W      = 6,
    parameter int GRAN_BYTES  = 256,
    parameter int GUARD_BYTES = 64,
    localparam int DSEL_W     = rxfa_pkg::DAT_FIELD_W,
    localparam int BEAT_W     = $clog2(BEAT_BYTES + 1),
    localparam int GRAN_SH    = $clog2(GRAN_BYTES),
    localparam int BCNT_W     = DSEL_W + GRAN_SH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [DSEL_W-1:0] depth_sel,
    input  logic [BEAT_W-1:0] wr_bytes,
    input  logic [BEAT_W-1:0] rd_bytes,
    input  logic              wr_eof,
    input  logic              rd_eof,
    output logic              alert
);
    rxfa_pkg::thr_cfg_t cfg;
    logic [BCNT_W-1:0]  byte_cnt;
    logic [FCNT_W-1:0]  frm_cnt;

    rxfa_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    rxfa_occupancy #(
        .DSEL_W  (DSEL_W),
        .BEAT_W  (BEAT_W),
        .GRAN_SH (GRAN_SH),
        .FCNT_W  (FCNT_W)
    ) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth_sel (depth_sel),
        .wr_bytes  (wr_bytes),
        .rd_bytes  (rd_bytes),
        .wr_eof    (wr_eof),
        .rd_eof    (rd_eof),
        .byte_cnt  (byte_cnt),
        .frm_cnt   (frm_cnt)
    );

    rxfa_compare #(
        .DSEL_W      (DSEL_W),
        .GRAN_SH     (GRAN_SH),
        .FCNT_W      (FCNT_W),
        .GUARD_BYTES (GUARD_BYTES)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .depth_sel (depth_sel),
        .byte_cnt  (byte_cnt),
        .frm_cnt   (frm_cnt),
        .alert     (alert)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!alert && reg_rdata == 32'h001F_00FF)); // R1
endmodule

// File: tb/sim_rxfa_top.sv
// Scoreboard bench: drivers push the expected alert for every cycle, and a
// monitor pops it and compares one clock edge later.
module sim_rxfa_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  depth_sel = 8'd3;
    logic [4:0]  wr_bytes = '0;
    logic [4:0]  rd_bytes = '0;
    logic        wr_eof = 1'b0;
    logic        rd_eof = 1'b0;
    logic        alert;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;
    item_t sb[$];

    // Reference state built from the requirements.
    int m_bytes = 0;
    int m_frames = 0;
    int m_fthr = 31;
    int m_dthr = 255;

    always #2.5 clk = ~clk;

    rxfa_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .depth_sel(depth_sel), .wr_bytes(wr_bytes),
        .rd_bytes(rd_bytes), .wr_eof(wr_eof), .rd_eof(rd_eof), .alert(alert)
    );

    function automatic bit model_alert();
        int need;
        int lim;
        int d;
        d = int'(depth_sel);
        need = (m_fthr > 23) ? 24 : m_fthr + 1;               // R3, R4
        if (m_dthr >= d) lim = (d + 1) * 256 - 64;            // R6, R7
        else             lim = (m_dthr + 1) * 256;            // R5
        return (m_frames >= need) || (m_bytes >= lim);        // R8
    endfunction

    // One clock of stimulus; the alert after this edge reflects the state before it (R11).
    task automatic cyc(input int wb, input int rb, input bit we, input bit re,
                       input bit rw, input logic [31:0] wd, input string tag);
        item_t it;
        int cap;
        @(negedge clk);
        wr_bytes = 5'(wb); rd_bytes = 5'(rb);
        wr_eof = we; rd_eof = re; reg_wr = rw; reg_wdata = wd;
        it.exp = model_alert();
        it.tag = tag;
        sb.push_back(it);
        cap = (int'(depth_sel) + 1) * 256;
        m_bytes = m_bytes + wb - rb;                          // R10
        if (m_bytes < 0) m_bytes = 0;
        if (m_bytes > cap) m_bytes = cap;
        if (we && !re && m_frames < 63) m_frames++;           // R9
        if (re && !we && m_frames > 0) m_frames--;
        if (rw) begin
            m_fthr = int'(wd[20:16]);
            m_dthr = int'(wd[7:0]);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 32'h0, tag);
    endtask

    task automatic reg_write(input logic [31:0] wd, input string tag);
        cyc(0, 0, 0, 0, 1, wd, tag);
        idle(1, tag);
    endtask

    task automatic check_rd(input logic [31:0] exp, input string tag);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s reg_rdata=%h expected=%h", tag, reg_rdata, exp);
        end
    endtask

    // Monitor: compare the alert just after each edge against the queued value.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (alert !== it.exp) begin
                    errors++;
                    $display("FAIL %s alert=%0b expected=%0b", it.tag, alert, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents and alert level
        check_rd(32'h001F_00FF, "R1 reset value");
        checks++;
        if (alert !== 1'b0) begin
            errors++;
            $display("FAIL R1 alert=%0b expected=0", alert);
        end
        idle(2, "R1 idle");

        // R2: reserved bits read zero
        reg_write(32'hFFFF_FFFF, "R2");
        check_rd(32'h001F_00FF, "R2 all-ones write");
        reg_write(32'hA5A2_5A3C, "R2");
        check_rd(32'h0002_003C, "R2 mixed write");

        // R3: frame field 2 -> 3 frames; byte field 0x3C clamped (R7)
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 0, 0, "R3 frame fill");
        idle(2, "R3 hold");
        // R9: simultaneous strobes leave the count unchanged
        cyc(0, 0, 1, 1, 0, 0, "R9 both strobes");
        cyc(0, 0, 1, 1, 0, 0, "R9 both strobes");
        idle(2, "R9 hold");
        cyc(0, 0, 0, 1, 0, 0, "R8 release");
        idle(2, "R8 released");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, "R9 drain");
        reg_write(32'h0000_003C, "R9 set one frame");
        cyc(0, 0, 1, 0, 0, 0, "R9 floor at zero");
        idle(2, "R9 one frame");
        cyc(0, 16, 0, 1, 0, 0, "R9 empty");
        idle(2, "R9 empty");

        // R5: byte field 1 below depth 3 -> 512 bytes
        reg_write(32'h001F_0001, "R5");
        for (int i = 0; i < 32; i++) cyc(16, 0, 0, 0, 0, 0, "R5 fill");
        idle(2, "R5 at limit");
        cyc(0, 16, 0, 0, 0, 0, "R8 release bytes");
        idle(2, "R8 below");

        // R6: byte field equal to depth -> 960 bytes
        reg_write(32'h001F_0003, "R6");
        for (int i = 0; i < 28; i++) cyc(16, 0, 0, 0, 0, 0, "R6 below guard");
        idle(2, "R6 944");
        cyc(16, 0, 0, 0, 0, 0, "R6 guard hit");
        idle(2, "R6 960");

        // R10: saturate at 1024, then back down
        for (int i = 0; i < 10; i++) cyc(16, 0, 0, 0, 0, 0, "R10 overfill");
        for (int i = 0; i < 4; i++) cyc(0, 16, 0, 0, 0, 0, "R10 cap");
        idle(2, "R10 960 after cap");
        cyc(0, 16, 0, 0, 0, 0, "R10 release");
        for (int i = 0; i < 80; i++) cyc(0, 16, 0, 0, 0, 0, "R10 underflow");
        for (int i = 0; i < 60; i++) cyc(16, 0, 0, 0, 0, 0, "R10 refill");
        idle(2, "R10 floor");
        for (int i = 0; i < 60; i++) cyc(0, 16, 0, 0, 0, 0, "R10 drain");

        // R4 and R7: field values above their limits
        reg_write(32'h001F_00FF, "R4");
        for (int i = 0; i < 23; i++) cyc(0, 0, 1, 0, 0, 0, "R4 23 frames");
        idle(2, "R4 below");
        cyc(0, 0, 1, 0, 0, 0, "R4 24th frame");
        idle(2, "R4 hit");
        for (int i = 0; i < 60; i++) cyc(16, 0, 0, 0, 0, 0, "R7 byte fill");
        // R8: one condition still holds after the other clears
        cyc(0, 0, 0, 1, 0, 0, "R8 bytes keep alert");
        idle(2, "R8 hold");
        cyc(0, 16, 0, 0, 0, 0, "R8 both clear");
        idle(3, "R8 final");

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule